// File: doc/BRIEF.md
# Privilege-Filtered Retired-Instruction Counter

This block keeps a 64-bit count of retired instructions and a companion 64-bit configuration register. The configuration register holds one inhibit bit per privilege level, including the two virtualised levels. While the hart runs in a level whose inhibit bit is set, retirements are not added to the count. The core drives the current privilege level and a per-cycle retire count. Software reaches both registers through a simple CSR port: address, write strobe, write data and registered read data.

The configuration register is legalised on write. Inhibit bits for levels the build does not implement are tied to zero. The overflow flag and every reserved bit read as zero. On a 32-bit build each 64-bit register is split into a low half and a high half, and each half has its own address. A parameter set selects the data width and which of supervisor, user and virtualised levels exist.

Top module: `ifilt_instret`

## Requirements
- R1: The privilege input `priv_mode` is encoded as {virt, level[1:0]}, where level 2'b11 is machine, 2'b01 is supervisor and 2'b00 is user. Virt=1 selects VS when level is supervisor and VU when level is user. Level 2'b10 is reserved and is never inhibited. With every inhibit bit clear, `instret_count` grows by `retire_cnt` (0 to 2) on each clock edge, in every level.
- R2: The configuration register lives at CSR address 0x322. Bit 62 inhibits machine, bit 61 supervisor, bit 60 user, bit 59 VS and bit 58 VU. When the bit for the level presented in a cycle is set, that cycle's retirements are not counted. A level change counts from the cycle in which it is presented.
- R3: A configuration write first governs the retirements of the following cycle. Retirements in the cycle of the write itself use the old setting.
- R4: Bit 63 (overflow flag) and bits 57:0 of the configuration register always read zero, and writes to them have no effect.
- R5: When virtualisation is not built (HAS_H=0), bits 59 and 58 read zero and ignore writes. The virt bit of `priv_mode` is then ignored, so a VS or VU encoding counts as supervisor or user.
- R6: The counter is writable at CSR address 0xB02. A write replaces the written bits, and in that cycle no increment is applied.
- R7: The count wraps modulo 2^64.
- R8: With XLEN=32, the configuration high half is at 0x722 and the counter high half is at 0xB82. A write to one half changes only those 32 bits, and a carry from the low half propagates into the high half.
- R9: A synchronous reset clears the count, the inhibit bits and `csr_rdata`.
- R10: `csr_rdata` is registered. One cycle after an address is presented, it shows the legalised value held at that address. An unmapped address reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 3 | Current privilege level {virt, level} |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| csr_addr | input | 12 | CSR address |
| csr_we | input | 1 | CSR write strobe |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Registered CSR read data |
| instret_count | output | 64 | Current count value |

## Verification
The bench sweeps every privilege encoding against single and mixed inhibit patterns. A design with swapped bit positions or a wrong virt decode would count in the wrong level. It writes the configuration while retirements are in flight. A design that gated with the freshly written value would lose the retirement of the write cycle.

Other directed cases each expose a specific fault:
- A counter write during an active retire exposes a design that adds the increment on top of the written value.
- An all-ones count exposes broken wrap.
- On a 32-bit build, all-ones writes expose reserved or unimplemented bits that stick.
- A low-half write followed by a carry exposes split halves that clobber each other or drop the carry.

// File: rtl/ifilt_pkg.sv
package ifilt_pkg;

  // Inhibit set, ordered as it sits in configuration bits 62 down to 58.
  typedef struct packed {
    logic m;
    logic s;
    logic u;
    logic vs;
    logic vu;
  } inh_t;

  typedef enum logic [1:0] {
    LVL_U   = 2'b00,
    LVL_S   = 2'b01,
    LVL_RSV = 2'b10,
    LVL_M   = 2'b11
  } lvl_e;

  localparam int INH_W   = 5;
  localparam int INH_LSB = 58;
  localparam int INH_MSB = INH_LSB + INH_W - 1;
  localparam int CFG_W   = 64;

  function automatic inh_t legal_mask(input bit has_s, input bit has_u,
                                      input bit has_h);
    inh_t r;
    r.m  = 1'b1;
    r.s  = has_s;
    r.u  = has_u;
    r.vs = has_h && has_s;
    r.vu = has_h && has_s;
    return r;
  endfunction

endpackage

// File: rtl/ifilt_cfg.sv
module ifilt_cfg
  import ifilt_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter bit          HAS_S     = 1'b1,
  parameter bit          HAS_U     = 1'b1,
  parameter bit          HAS_H     = 1'b1,
  parameter logic [11:0] CFG_ADDR  = 12'h322,
  parameter logic [11:0] CFG_ADDRH = 12'h722
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [11:0]      csr_addr,
  input  logic             csr_we,
  input  logic [XLEN-1:0]  csr_wdata,
  output inh_t             inh_q,
  output logic [CFG_W-1:0] cfg_view
);

  localparam inh_t LEGAL = legal_mask(HAS_S, HAS_U, HAS_H);
  localparam int   HI_LSB = INH_LSB - 32;
  localparam int   HI_MSB = INH_MSB - 32;

  inh_t inh_wr;
  logic hit;
  logic unused_wd;

  assign unused_wd = ^csr_wdata;

  generate
    if (XLEN == 64) begin : g_x64
      assign hit    = csr_we && (csr_addr == CFG_ADDR);
      assign inh_wr = inh_t'(csr_wdata[INH_MSB:INH_LSB]);
    end else begin : g_x32
      // The low half holds only reserved bits, so only the high half writes.
      assign hit    = csr_we && (csr_addr == CFG_ADDRH);
      assign inh_wr = inh_t'(csr_wdata[HI_MSB:HI_LSB]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q <= '0;
    end else if (hit) begin
      inh_q <= inh_wr & LEGAL;
    end
  end

  assign cfg_view = {1'b0, inh_q, {INH_LSB{1'b0}}};

endmodule

// File: rtl/ifilt_gate.sv
module ifilt_gate
  import ifilt_pkg::*;
#(
  parameter bit HAS_H = 1'b1,
  parameter int RET_W = 2
) (
  input  logic [2:0]       priv_mode,
  input  inh_t             inh,
  input  logic [RET_W-1:0] retire_cnt,
  output logic [RET_W-1:0] add_amt
);

  logic virt;
  lvl_e lvl;
  logic block;

  assign lvl = lvl_e'(priv_mode[1:0]);

  generate
    if (HAS_H) begin : g_virt
      assign virt = priv_mode[2];
    end else begin : g_novirt
      logic unused_virt;
      assign unused_virt = priv_mode[2];
      assign virt        = 1'b0;
    end
  endgenerate

  always_comb begin
    unique case (lvl)
      LVL_M:   block = inh.m;
      LVL_S:   block = virt ? inh.vs : inh.s;
      LVL_U:   block = virt ? inh.vu : inh.u;
      default: block = 1'b0;
    endcase
    add_amt = block ? '0 : retire_cnt;
  end

endmodule

// File: rtl/ifilt_ctr.sv
module ifilt_ctr #(
  parameter int          XLEN      = 64,
  parameter int          CNT_W     = 64,
  parameter int          RET_W     = 2,
  parameter logic [11:0] CNT_ADDR  = 12'hB02,
  parameter logic [11:0] CNT_ADDRH = 12'hB82
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [11:0]      csr_addr,
  input  logic             csr_we,
  input  logic [XLEN-1:0]  csr_wdata,
  input  logic [RET_W-1:0] add_amt,
  output logic [CNT_W-1:0] cnt_q
);

  localparam int HALF = CNT_W / 2;

  logic [CNT_W-1:0] cnt_nx;

  generate
    if (XLEN == 64) begin : g_x64
      always_comb begin
        if (csr_we && csr_addr == CNT_ADDR) begin
          cnt_nx = CNT_W'(csr_wdata);
        end else begin
          cnt_nx = cnt_q + CNT_W'(add_amt);
        end
      end
    end else begin : g_x32
      always_comb begin
        if (csr_we && csr_addr == CNT_ADDR) begin
          cnt_nx = {cnt_q[CNT_W-1:HALF], csr_wdata[HALF-1:0]};
        end else if (csr_we && csr_addr == CNT_ADDRH) begin
          cnt_nx = {csr_wdata[HALF-1:0], cnt_q[HALF-1:0]};
        end else begin
          cnt_nx = cnt_q + CNT_W'(add_amt);
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nx;
  end

endmodule

// File: rtl/ifilt_instret.sv
module ifilt_instret
  import ifilt_pkg::*;
#(
  parameter int          XLEN      = 64,
  parameter int          RET_W     = 2,
  parameter bit          HAS_S     = 1'b1,
  parameter bit          HAS_U     = 1'b1,
  parameter bit          HAS_H     = 1'b1,
  parameter logic [11:0] CFG_ADDR  = 12'h322,
  parameter logic [11:0] CFG_ADDRH = 12'h722,
  parameter logic [11:0] CNT_ADDR  = 12'hB02,
  parameter logic [11:0] CNT_ADDRH = 12'hB82
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       priv_mode,
  input  logic [RET_W-1:0] retire_cnt,
  input  logic [11:0]      csr_addr,
  input  logic             csr_we,
  input  logic [XLEN-1:0]  csr_wdata,
  output logic [XLEN-1:0]  csr_rdata,
  output logic [63:0]      instret_count
);

  localparam int CNT_W = 64;

  inh_t             inh_q;
  logic [CFG_W-1:0] cfg_view;
  logic [RET_W-1:0] add_amt;
  logic [CNT_W-1:0] cnt_q;
  logic [XLEN-1:0]  rd_nx;

  ifilt_cfg #(
    .XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_H(HAS_H),
    .CFG_ADDR(CFG_ADDR), .CFG_ADDRH(CFG_ADDRH)
  ) u_cfg (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .inh_q(inh_q), .cfg_view(cfg_view)
  );

  ifilt_gate #(.HAS_H(HAS_H), .RET_W(RET_W)) u_gate (
    .priv_mode(priv_mode), .inh(inh_q), .retire_cnt(retire_cnt),
    .add_amt(add_amt)
  );

  ifilt_ctr #(
    .XLEN(XLEN), .CNT_W(CNT_W), .RET_W(RET_W),
    .CNT_ADDR(CNT_ADDR), .CNT_ADDRH(CNT_ADDRH)
  ) u_ctr (
    .clk(clk), .rst(rst), .csr_addr(csr_addr), .csr_we(csr_we),
    .csr_wdata(csr_wdata), .add_amt(add_amt), .cnt_q(cnt_q)
  );

  generate
    if (XLEN == 64) begin : g_rd64
      always_comb begin
        if (csr_addr == CFG_ADDR)      rd_nx = cfg_view;
        else if (csr_addr == CNT_ADDR) rd_nx = cnt_q;
        else                           rd_nx = '0;
      end
    end else begin : g_rd32
      always_comb begin
        if (csr_addr == CFG_ADDR)       rd_nx = cfg_view[31:0];
        else if (csr_addr == CFG_ADDRH) rd_nx = cfg_view[63:32];
        else if (csr_addr == CNT_ADDR)  rd_nx = cnt_q[31:0];
        else if (csr_addr == CNT_ADDRH) rd_nx = cnt_q[63:32];
        else                            rd_nx = '0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) csr_rdata <= '0;
    else     csr_rdata <= rd_nx;
  end

  assign instret_count = cnt_q;

endmodule

// File: rtl/ifilt_chk.sv
module ifilt_chk #(
  parameter int          XLEN      = 64,
  parameter int          RET_W     = 2,
  parameter bit          HAS_S     = 1'b1,
  parameter bit          HAS_U     = 1'b1,
  parameter bit          HAS_H     = 1'b1,
  parameter logic [11:0] CFG_ADDR  = 12'h322,
  parameter logic [11:0] CNT_ADDR  = 12'hB02,
  parameter logic [11:0] CNT_ADDRH = 12'hB82
) (
  input logic             clk,
  input logic             rst,
  input logic [2:0]       priv_mode,
  input logic [RET_W-1:0] retire_cnt,
  input logic [11:0]      csr_addr,
  input logic             csr_we,
  input logic [XLEN-1:0]  csr_wdata,
  input logic [XLEN-1:0]  csr_rdata,
  input logic [63:0]      instret_count,
  input logic [4:0]       inh_q
);

  // Bit order of inh_q: [4] M, [3] S, [2] U, [1] VS, [0] VU.
  logic [4:0] legal;
  logic       cnt_wr;
  logic       blocked;
  logic       v;

  assign legal  = {1'b1, HAS_S, HAS_U, HAS_H && HAS_S, HAS_H && HAS_S};
  assign cnt_wr = csr_we && ((csr_addr == CNT_ADDR) ||
                             (XLEN == 32 && csr_addr == CNT_ADDRH));
  assign v      = HAS_H && priv_mode[2];

  always_comb begin
    blocked = 1'b0;
    if (priv_mode[1:0] == 2'd3)      blocked = inh_q[4];
    else if (priv_mode[1:0] == 2'd1) blocked = v ? inh_q[1] : inh_q[3];
    else if (priv_mode[1:0] == 2'd0) blocked = v ? inh_q[0] : inh_q[2];
  end

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && !blocked) |=>
      instret_count == $past(instret_count) + 64'($past(retire_cnt)));

  assert_inhibit_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!cnt_wr && blocked) |=> $stable(instret_count));

  assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (inh_q & ~legal) == 5'b0);

  generate
    if (XLEN == 64) begin : g_a64
      assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == CFG_ADDR) |=>
          (csr_rdata[63] == 1'b0 && csr_rdata[57:0] == 58'b0));
      assert_cnt_write_R6: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == CNT_ADDR) |=>
          instret_count == $past(csr_wdata));
    end else begin : g_a32
      assert_reserved_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == CFG_ADDR) |=> csr_rdata == '0);
      assert_half_write_R8: assert property (@(posedge clk) disable iff (rst)
        (csr_we && csr_addr == CNT_ADDR) |=>
          (instret_count[31:0] == $past(csr_wdata) &&
           instret_count[63:32] == $past(instret_count[63:32])));
    end
  endgenerate

endmodule

bind ifilt_instret ifilt_chk #(
  .XLEN(XLEN), .RET_W(RET_W), .HAS_S(HAS_S), .HAS_U(HAS_U), .HAS_H(HAS_H),
  .CFG_ADDR(CFG_ADDR), .CNT_ADDR(CNT_ADDR), .CNT_ADDRH(CNT_ADDRH)
) u_chk (
  .clk(clk), .rst(rst), .priv_mode(priv_mode), .retire_cnt(retire_cnt),
  .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
  .csr_rdata(csr_rdata), .instret_count(instret_count), .inh_q(inh_q)
);

// File: tb/tb_ifilt_instret.sv
`timescale 1ns/1ps
module tb_ifilt_instret;

  localparam logic [11:0] A_CFG  = 12'h322;
  localparam logic [11:0] A_CFGH = 12'h722;
  localparam logic [11:0] A_CNT  = 12'hB02;
  localparam logic [11:0] A_CNTH = 12'hB82;
  localparam logic [2:0]  MD_M = 3'b011, MD_S = 3'b001, MD_U = 3'b000;
  localparam logic [2:0]  MD_VS = 3'b101, MD_VU = 3'b100, MD_RSV = 3'b010;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  priv_mode = MD_M;
  logic [1:0]  retire_cnt = '0;
  logic [11:0] csr_addr = '0;
  logic        csr_we = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] rdata64, count64;
  logic [31:0] rdata32;
  logic [63:0] count32;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  ifilt_instret dut (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .retire_cnt(retire_cnt),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
    .csr_rdata(rdata64), .instret_count(count64)
  );

  ifilt_instret #(.XLEN(32), .HAS_H(1'b0)) dut32 (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .retire_cnt(retire_cnt),
    .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata[31:0]),
    .csr_rdata(rdata32), .instret_count(count32)
  );

  // {inhibit[4:0] = M,S,U,VS,VU ; mode[2:0] ; retire[1:0] ; expected delta over 4 cycles}
  localparam logic [15:0] VEC [10] = '{
    {5'b00000, MD_M,   2'd1, 6'd4},
    {5'b10000, MD_M,   2'd2, 6'd0},
    {5'b10000, MD_S,   2'd2, 6'd8},
    {5'b01000, MD_S,   2'd1, 6'd0},
    {5'b00100, MD_U,   2'd2, 6'd0},
    {5'b00100, MD_VU,  2'd1, 6'd4},
    {5'b00010, MD_VS,  2'd2, 6'd0},
    {5'b00001, MD_VU,  2'd1, 6'd0},
    {5'b11110, MD_VU,  2'd2, 6'd8},
    {5'b00001, MD_RSV, 2'd1, 6'd4}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = '0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    csr_addr = a; csr_we = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] c0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9 count after reset", count64, 64'd0);
    chk("R9 rdata after reset", rdata64, 64'd0);
    rd(A_CFG);
    chk("R9 cfg after reset", rdata64, 64'd0);

    // R1 R2: table walk over modes and inhibit patterns
    for (int i = 0; i < 10; i++) begin
      wr(A_CFG, {1'b0, VEC[i][15:11], 58'b0});
      rd(A_CFG);
      chk("R2 cfg readback", rdata64, {1'b0, VEC[i][15:11], 58'b0});
      c0 = count64;
      priv_mode = VEC[i][10:8];
      retire_cnt = VEC[i][7:6];
      repeat (4) @(negedge clk);
      retire_cnt = '0;
      chk("R1/R2 delta", count64 - c0, 64'(VEC[i][5:0]));
    end

    // R4: reserved and overflow bits
    wr(A_CFG, '1);
    rd(A_CFG);
    chk("R4 all-ones cfg readback", rdata64, 64'h7C00_0000_0000_0000);

    // R3: write lands the cycle after
    wr(A_CFG, 64'd0);
    @(negedge clk);
    priv_mode = MD_M; retire_cnt = 2'd1; c0 = count64;
    csr_addr = A_CFG; csr_wdata = 64'h4000_0000_0000_0000; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = '0;
    repeat (2) @(negedge clk);
    retire_cnt = '0;
    chk("R3 write-cycle retire kept", count64 - c0, 64'd1);

    // R6: software write beats the increment
    wr(A_CFG, 64'd0);
    @(negedge clk);
    retire_cnt = 2'd2; csr_addr = A_CNT; csr_wdata = 64'd100; csr_we = 1'b1;
    @(negedge clk);
    csr_we = 1'b0; csr_addr = '0;
    chk("R6 write priority", count64, 64'd100);
    @(negedge clk);
    retire_cnt = '0;
    chk("R6 count resumes", count64, 64'd102);

    // R10: read counter through CSR
    rd(A_CNT);
    chk("R10 counter readback", rdata64, 64'd102);
    rd(12'h123);
    chk("R10 unmapped reads zero", rdata64, 64'd0);

    // R7: wrap
    wr(A_CNT, '1);
    @(negedge clk);
    retire_cnt = 2'd2;
    @(negedge clk);
    retire_cnt = '0;
    chk("R7 wrap", count64, 64'd1);

    // R5: 32-bit build without virtualisation
    wr(A_CFGH, 64'hFFFF_FFFF);
    rd(A_CFGH);
    chk("R5 unimplemented bits zero", {32'd0, rdata32}, 64'h7000_0000);
    rd(A_CFG);
    chk("R4 low half zero", {32'd0, rdata32}, 64'd0);
    wr(A_CFGH, 64'h0C00_0000);
    rd(A_CFGH);
    chk("R5 VS/VU bits ignore writes", {32'd0, rdata32}, 64'd0);
    c0 = count32;
    priv_mode = MD_VS; retire_cnt = 2'd1;
    repeat (4) @(negedge clk);
    retire_cnt = '0;
    chk("R5 VS counted as S", count32 - c0, 64'd4);
    wr(A_CFGH, 64'h2000_0000);
    c0 = count32;
    retire_cnt = 2'd1;
    repeat (4) @(negedge clk);
    retire_cnt = '0;
    chk("R5 virt bit ignored, S inhibit applies", count32 - c0, 64'd0);

    // R8: split halves
    wr(A_CFGH, 64'd0);
    priv_mode = MD_M;
    wr(A_CNT, 64'h1234_5678);
    wr(A_CNTH, 64'h9ABC_DEF0);
    chk("R8 halves assembled", count32, 64'h9ABC_DEF0_1234_5678);
    wr(A_CNT, 64'hFFFF_FFFF);
    chk("R8 low write keeps high", count32, 64'h9ABC_DEF0_FFFF_FFFF);
    @(negedge clk);
    retire_cnt = 2'd1;
    @(negedge clk);
    retire_cnt = '0;
    chk("R8 carry into high half", count32, 64'h9ABC_DEF1_0000_0000);
    rd(A_CNTH);
    chk("R8 high half readback", {32'd0, rdata32}, 64'h9ABC_DEF1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule